// File: doc/BRIEF.md
# Parallel Panel Sync Timing Generator

This block produces the raster timing for a parallel RGB panel link in the pixel clock domain. A horizontal and a vertical position counter sweep each line in a fixed order: the active pixels first, then the front porch, the sync pulse and the back porch. Each frame is built the same way from lines. The position, HSYNC, VSYNC and a data-enable strobe are decoded from the counters. A separate output tells downstream logic which DCLK edge to launch pixel data on. An inversion flag flips once per line or once per frame, for the panel's drive-polarity scheme.

The timing comes from a 2-bit mode selector. Three entries hold fixed panel timings. The fourth is set by module parameters, so a smaller or unusual panel needs no edit to the table. A 4-bit polarity word sets the active level of each strobe, and a 2-bit field selects which strobes are emitted. Strobes that are not emitted are held at their inactive level.

The mode, polarity, emission field and inversion choice are sampled only when the raster wraps from the last pixel of a frame to the first, so a change can never produce a shortened pulse. A synchronous reset returns the counters to the origin and loads these settings directly from the inputs. The counters advance only on clocks where the pixel enable is high.

Top module: `dpi_sync_gen`

## Requirements
- R1: Mode select value 0 gives 320 active pixels, front porch 38, sync 1 and back porch 50 (a 409-clock line), with 240 active lines, vertical front porch 4, sync 1 line and 262 lines per frame. Value 1 gives 320 active pixels, front porch 359, sync 1 and back porch 241 (a 921-clock line), with the same vertical timing as value 0. Value 2 gives 640 active pixels, front porch 3, sync 1 and back porch 272 (916 clocks), with 480 active lines, front porch 4, sync 1 line and 500 lines per frame. Value 3 takes all eight values from the module parameters.
- R2: The horizontal position advances by one on each clock with the pixel enable high, and holds on clocks with it low. After the last pixel of a line it returns to 0 and the vertical position advances; after the last line of a frame, the vertical position returns to 0.
- R3: When it is emitted, DE is at its active level exactly when the horizontal position is below the active width and the vertical position is below the active height.
- R4: Within a line, HSYNC is active for positions from active width plus front porch up to, but not including, that value plus the sync width. VSYNC follows the same rule on the vertical position, using the vertical values.
- R5: The emission field selects the strobes: 00 emits HSYNC and VSYNC, 01 emits HSYNC, VSYNC and DE, 10 emits DE only, and 11 emits none. A strobe that is not emitted stays at its inactive level.
- R6: Polarity word bit 1 sets HSYNC, bit 2 sets VSYNC and bit 3 sets DE, with 1 meaning active high and 0 active low. Bit 0 is driven out as the DCLK edge select, where 1 means the rising edge.
- R7: With the line-inversion input at 1, the inversion output toggles at every wrap from the last pixel of a line to the first. With it at 0, the output toggles only at the wrap from the last pixel of a frame.
- R8: Mode, polarity, emission field and inversion choice are loaded only on the enabled clock that wraps the raster from the last pixel of a frame. Changes at any other time have no effect on the outputs until then.
- R9: A synchronous reset sets both positions and the inversion output to 0 and loads the settings from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Advance the raster on this clock |
| mode_sel | input | 2 | Timing table entry |
| pol_cfg | input | 4 | Polarity word: bit0 DCLK edge, bit1 HSYNC, bit2 VSYNC, bit3 DE |
| sync_sel | input | 2 | Strobe emission field |
| line_inv | input | 1 | 1 toggles inversion per line, 0 per frame |
| h_pos | output | 12 | Horizontal position |
| v_pos | output | 12 | Vertical position |
| hsync_o | output | 1 | Horizontal sync strobe |
| vsync_o | output | 1 | Vertical sync strobe |
| de_o | output | 1 | Data enable strobe |
| dclk_rise_o | output | 1 | 1 when pixel data launches on the rising DCLK edge |
| inv_o | output | 1 | Line or frame inversion flag |

## Verification
The assertions check several rules on every cycle:
- the horizontal position never reaches the line total, and both positions hold while the enable is low;
- the vertical position moves only at the end of a line;
- the latched settings stay fixed except at the frame wrap, and there they take the input values;
- a disabled configuration keeps every strobe inactive, and DE never goes active outside the active area or in a mode that does not emit it;
- the inversion flag holds inside a line and flips at every line end in line mode.

The exact pulse positions and widths, the table values of each mode, the polarity of each strobe, and the per-frame toggle count can only be shown by the bench's scenarios. The bench compares every output on every cycle against a model of its own, built from the requirements. This includes a full frame of mode 0 and a configuration change made in the middle of a frame.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

    // width of every timing value and position counter
    localparam int TW = 12;

    // bit positions inside the polarity word
    localparam int POL_DCLK = 0;
    localparam int POL_HS   = 1;
    localparam int POL_VS   = 2;
    localparam int POL_DE   = 3;

    typedef logic [TW-1:0] tval_t;

    typedef enum logic [1:0] {
        SM_HV   = 2'b00,
        SM_HVDE = 2'b01,
        SM_DE   = 2'b10,
        SM_OFF  = 2'b11
    } smode_e;

    // one timing table entry
    typedef struct packed {
        tval_t h_act;
        tval_t h_fp;
        tval_t h_sw;
        tval_t h_bp;
        tval_t v_act;
        tval_t v_fp;
        tval_t v_sw;
        tval_t v_bp;
    } tmg_t;

    // boundaries derived from a table entry
    typedef struct packed {
        tval_t h_act;
        tval_t h_ss;
        tval_t h_se;
        tval_t h_tot;
        tval_t v_act;
        tval_t v_ss;
        tval_t v_se;
        tval_t v_tot;
    } bnd_t;

    // settings latched at the frame wrap
    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] pol;
        smode_e     smode;
        logic       linv;
    } cfg_t;

endpackage

// File: rtl/dsg_mode_lut.sv
module dsg_mode_lut
    import dsg_pkg::*;
#(
    parameter int CH_ACT = 8,
    parameter int CH_FP  = 2,
    parameter int CH_SW  = 2,
    parameter int CH_BP  = 3,
    parameter int CV_ACT = 4,
    parameter int CV_FP  = 1,
    parameter int CV_SW  = 2,
    parameter int CV_BP  = 2
) (
    input  logic [1:0] mode,
    output bnd_t       bnd
);

    localparam int NMODES = 4;

    // entries 0..2 are fixed panel timings, entry 3 is parameter defined
    localparam tmg_t TBL [NMODES] = '{
        '{tval_t'(320), tval_t'(38),  tval_t'(1), tval_t'(50),
          tval_t'(240), tval_t'(4),   tval_t'(1), tval_t'(17)},
        '{tval_t'(320), tval_t'(359), tval_t'(1), tval_t'(241),
          tval_t'(240), tval_t'(4),   tval_t'(1), tval_t'(17)},
        '{tval_t'(640), tval_t'(3),   tval_t'(1), tval_t'(272),
          tval_t'(480), tval_t'(4),   tval_t'(1), tval_t'(15)},
        '{tval_t'(CH_ACT), tval_t'(CH_FP), tval_t'(CH_SW), tval_t'(CH_BP),
          tval_t'(CV_ACT), tval_t'(CV_FP), tval_t'(CV_SW), tval_t'(CV_BP)}
    };

    tmg_t sel;

    always_comb begin
        sel       = TBL[mode];
        bnd.h_act = sel.h_act;
        bnd.h_ss  = sel.h_act + sel.h_fp;
        bnd.h_se  = sel.h_act + sel.h_fp + sel.h_sw;
        bnd.h_tot = sel.h_act + sel.h_fp + sel.h_sw + sel.h_bp;
        bnd.v_act = sel.v_act;
        bnd.v_ss  = sel.v_act + sel.v_fp;
        bnd.v_se  = sel.v_act + sel.v_fp + sel.v_sw;
        bnd.v_tot = sel.v_act + sel.v_fp + sel.v_sw + sel.v_bp;
    end

endmodule

// File: rtl/dsg_raster.sv
module dsg_raster
    import dsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  tval_t h_tot,
    input  tval_t v_tot,
    output tval_t h_q,
    output tval_t v_q,
    output logic  line_end,
    output logic  frame_end
);

    typedef struct packed {
        tval_t h;
        tval_t v;
    } pos_t;

    pos_t pos_d, pos_q;

    assign h_q       = pos_q.h;
    assign v_q       = pos_q.v;
    assign line_end  = (pos_q.h == h_tot - tval_t'(1));
    assign frame_end = line_end && (pos_q.v == v_tot - tval_t'(1));

    always_comb begin
        pos_d = pos_q;
        if (en) begin
            if (line_end) begin
                pos_d.h = '0;
                pos_d.v = frame_end ? '0 : pos_q.v + tval_t'(1);
            end else begin
                pos_d.h = pos_q.h + tval_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    AST_H_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q.h < h_tot);                                                       // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(pos_q.h) && $stable(pos_q.v)));                        // R2
    AST_V_AT_EOL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !line_end) |=> $stable(pos_q.v));                                // R2

endmodule

// File: rtl/dsg_sync_out.sv
module dsg_sync_out
    import dsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  tval_t      h,
    input  tval_t      v,
    input  logic       line_end,
    input  logic       frame_end,
    input  tval_t      h_act,
    input  tval_t      h_ss,
    input  tval_t      h_se,
    input  tval_t      v_act,
    input  tval_t      v_ss,
    input  tval_t      v_se,
    input  logic [3:0] pol,
    input  smode_e     smode,
    input  logic       linv,
    output logic       hsync_o,
    output logic       vsync_o,
    output logic       de_o,
    output logic       dclk_rise_o,
    output logic       inv_o
);

    typedef struct packed {
        logic inv;
    } inv_st_t;

    inv_st_t st_d, st_q;

    logic in_act, in_hs, in_vs;
    logic emit_hv, emit_de;

    always_comb begin
        in_act = (h < h_act) && (v < v_act);
        in_hs  = (h >= h_ss) && (h < h_se);
        in_vs  = (v >= v_ss) && (v < v_se);
        case (smode)
            SM_HV:   begin emit_hv = 1'b1; emit_de = 1'b0; end
            SM_HVDE: begin emit_hv = 1'b1; emit_de = 1'b1; end
            SM_DE:   begin emit_hv = 1'b0; emit_de = 1'b1; end
            default: begin emit_hv = 1'b0; emit_de = 1'b0; end
        endcase
        hsync_o     = (emit_hv && in_hs)  ? pol[POL_HS] : ~pol[POL_HS];
        vsync_o     = (emit_hv && in_vs)  ? pol[POL_VS] : ~pol[POL_VS];
        de_o        = (emit_de && in_act) ? pol[POL_DE] : ~pol[POL_DE];
        dclk_rise_o = pol[POL_DCLK];
    end

    always_comb begin
        st_d = st_q;
        if (en && (linv ? line_end : frame_end))
            st_d.inv = ~st_q.inv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign inv_o = st_q.inv;

    AST_DE_IN_AREA: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o == pol[POL_DE]) |-> ((h < h_act) && (v < v_act)));                // R3
    AST_DE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o == pol[POL_DE]) |-> (smode == SM_HVDE || smode == SM_DE));        // R5
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (smode == SM_OFF) |-> (hsync_o != pol[POL_HS] && vsync_o != pol[POL_VS]
                               && de_o != pol[POL_DE]));                        // R5
    AST_INV_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && line_end && linv) |=> (inv_o != $past(inv_o)));                  // R7
    AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !line_end) |=> $stable(inv_o));                                 // R7

endmodule

// File: rtl/dpi_sync_gen.sv
module dpi_sync_gen
    import dsg_pkg::*;
#(
    parameter int CH_ACT = 8,
    parameter int CH_FP  = 2,
    parameter int CH_SW  = 2,
    parameter int CH_BP  = 3,
    parameter int CV_ACT = 4,
    parameter int CV_FP  = 1,
    parameter int CV_SW  = 2,
    parameter int CV_BP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic [1:0]       mode_sel,
    input  logic [3:0]       pol_cfg,
    input  logic [1:0]       sync_sel,
    input  logic             line_inv,
    output logic [TW-1:0]    h_pos,
    output logic [TW-1:0]    v_pos,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             dclk_rise_o,
    output logic             inv_o
);

    cfg_t  cfg_live, cfg_d, cfg_q;
    bnd_t  bnd;
    logic  line_end, frame_end;
    tval_t h_w, v_w;

    assign cfg_live = '{mode: mode_sel, pol: pol_cfg,
                        smode: smode_e'(sync_sel), linv: line_inv};

    // settings move only at the frame wrap so no pulse is ever cut short
    always_comb begin
        cfg_d = cfg_q;
        if (pix_en && frame_end)
            cfg_d = cfg_live;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_live;
        else        cfg_q <= cfg_d;
    end

    dsg_mode_lut #(
        .CH_ACT(CH_ACT), .CH_FP(CH_FP), .CH_SW(CH_SW), .CH_BP(CH_BP),
        .CV_ACT(CV_ACT), .CV_FP(CV_FP), .CV_SW(CV_SW), .CV_BP(CV_BP)
    ) u_lut (
        .mode (cfg_q.mode),
        .bnd  (bnd)
    );

    dsg_raster u_raster (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (pix_en),
        .h_tot     (bnd.h_tot),
        .v_tot     (bnd.v_tot),
        .h_q       (h_w),
        .v_q       (v_w),
        .line_end  (line_end),
        .frame_end (frame_end)
    );

    dsg_sync_out u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (pix_en),
        .h           (h_w),
        .v           (v_w),
        .line_end    (line_end),
        .frame_end   (frame_end),
        .h_act       (bnd.h_act),
        .h_ss        (bnd.h_ss),
        .h_se        (bnd.h_se),
        .v_act       (bnd.v_act),
        .v_ss        (bnd.v_ss),
        .v_se        (bnd.v_se),
        .pol         (cfg_q.pol),
        .smode       (cfg_q.smode),
        .linv        (cfg_q.linv),
        .hsync_o     (hsync_o),
        .vsync_o     (vsync_o),
        .de_o        (de_o),
        .dclk_rise_o (dclk_rise_o),
        .inv_o       (inv_o)
    );

    assign h_pos = h_w;
    assign v_pos = v_w;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_en && frame_end) |=> $stable(cfg_q));                             // R8
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && frame_end) |=> (cfg_q == $past(cfg_live)));                  // R8

endmodule

// File: tb/dpi_sync_gen_tb.sv
`timescale 1ns/1ps
module dpi_sync_gen_tb;

    localparam int CHA = 8, CHF = 2, CHS = 2, CHB = 3;
    localparam int CVA = 4, CVF = 1, CVS = 2, CVB = 2;
    localparam int CFRAME = (CHA + CHF + CHS + CHB) * (CVA + CVF + CVS + CVB);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic [1:0]  mode_sel = 2'd3;
    logic [3:0]  pol_cfg = 4'b1001;
    logic [1:0]  sync_sel = 2'b01;
    logic        line_inv = 1'b1;
    logic [11:0] h_pos, v_pos;
    logic        hsync_o, vsync_o, de_o, dclk_rise_o, inv_o;

    int n_chk = 0;
    int n_fail = 0;

    // bench model state
    int         mh, mv;
    logic [1:0] m_mode, m_sync;
    logic [3:0] m_pol;
    logic       m_linv, m_inv;

    always #2 clk = ~clk;

    dpi_sync_gen #(
        .CH_ACT(CHA), .CH_FP(CHF), .CH_SW(CHS), .CH_BP(CHB),
        .CV_ACT(CVA), .CV_FP(CVF), .CV_SW(CVS), .CV_BP(CVB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .mode_sel(mode_sel),
        .pol_cfg(pol_cfg), .sync_sel(sync_sel), .line_inv(line_inv),
        .h_pos(h_pos), .v_pos(v_pos), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .dclk_rise_o(dclk_rise_o), .inv_o(inv_o)
    );

    // timing table from R1
    function automatic void tim(input logic [1:0] md, output int ha, output int hf,
                                output int hs, output int hb, output int va,
                                output int vf, output int vs, output int vb);
        case (md)
            2'd0: begin ha = 320; hf = 38;  hs = 1; hb = 50;  va = 240; vf = 4; vs = 1; vb = 17; end
            2'd1: begin ha = 320; hf = 359; hs = 1; hb = 241; va = 240; vf = 4; vs = 1; vb = 17; end
            2'd2: begin ha = 640; hf = 3;   hs = 1; hb = 272; va = 480; vf = 4; vs = 1; vb = 15; end
            default: begin ha = CHA; hf = CHF; hs = CHS; hb = CHB; va = CVA; vf = CVF; vs = CVS; vb = CVB; end
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R3 R4 R5 R6: compare every output with the model
    task automatic cmp_all(input string tag);
        int ha, hf, hs, hb, va, vf, vs, vb;
        logic hact, hsa, vsa, e_hs, e_vs, e_de;
        logic [31:0] act, exp;
        tim(m_mode, ha, hf, hs, hb, va, vf, vs, vb);
        hact = (mh < ha) && (mv < va);
        hsa  = (mh >= ha + hf) && (mh < ha + hf + hs);
        vsa  = (mv >= va + vf) && (mv < va + vf + vs);
        e_hs = (!m_sync[1] && hsa) ? m_pol[1] : !m_pol[1];
        e_vs = (!m_sync[1] && vsa) ? m_pol[2] : !m_pol[2];
        e_de = ((m_sync == 2'b01 || m_sync == 2'b10) && hact) ? m_pol[3] : !m_pol[3];
        exp = {3'b000, 12'(mh), 12'(mv), e_hs, e_vs, e_de, m_pol[0], m_inv};
        act = {3'b000, h_pos, v_pos, hsync_o, vsync_o, de_o, dclk_rise_o, inv_o};
        check($sformatf("%s h=%0d v=%0d", tag, mh, mv), act, exp);
    endtask

    task automatic step(input logic en, input string tag);
        int ha, hf, hs, hb, va, vf, vs, vb;
        logic le, fe;
        pix_en = en;
        @(posedge clk);
        if (en) begin
            tim(m_mode, ha, hf, hs, hb, va, vf, vs, vb);
            le = (mh == ha + hf + hs + hb - 1);
            fe = le && (mv == va + vf + vs + vb - 1);
            if (m_linv ? le : fe) m_inv = !m_inv;
            if (le) begin
                mh = 0;
                mv = fe ? 0 : mv + 1;
            end else begin
                mh = mh + 1;
            end
            if (fe) begin
                m_mode = mode_sel; m_pol = pol_cfg; m_sync = sync_sel; m_linv = line_inv;
            end
        end
        @(negedge clk);
        cmp_all(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, tag);
    endtask

    task automatic do_reset(input logic [1:0] md, input logic [3:0] pl,
                            input logic [1:0] sm, input logic li);
        @(negedge clk);
        mode_sel = md; pol_cfg = pl; sync_sel = sm; line_inv = li;
        pix_en = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mh = 0; mv = 0; m_inv = 1'b0;
        m_mode = md; m_pol = pl; m_sync = sm; m_linv = li;
        cmp_all("R9 reset state");
    endtask

    task automatic test_reset();
        do_reset(2'd3, 4'b1001, 2'b01, 1'b1);
        // R9 R6: origin, active-low syncs idle high, DE active at origin
        check("R9 explicit", {20'd0, h_pos}, 32'd0);
        check("R6 idle levels", {27'd0, hsync_o, vsync_o, de_o, dclk_rise_o, inv_o}, 32'b11110);
    endtask

    task automatic test_frame();
        do_reset(2'd3, 4'b1001, 2'b01, 1'b1);
        run(2 * CFRAME, "R3/R4 custom frame");
    endtask

    task automatic test_enable();
        do_reset(2'd3, 4'b1001, 2'b00, 1'b1);
        for (int i = 0; i < 60; i++) step(i % 3 != 0, "R2 enable gating");
        for (int i = 0; i < 5; i++) step(1'b0, "R2 idle hold");
    endtask

    task automatic test_smodes();
        for (int s = 0; s < 4; s++) begin
            do_reset(2'd3, 4'b1001, 2'(s), 1'b1);
            run(CFRAME, "R5 emission field");
        end
    endtask

    task automatic test_polarity();
        do_reset(2'd3, 4'b0110, 2'b01, 1'b1);
        run(CFRAME, "R6 polarity 0110");
        do_reset(2'd3, 4'b1111, 2'b01, 1'b0);
        run(CFRAME, "R6 polarity 1111");
    endtask

    task automatic test_inversion();
        int tog;
        logic prev;
        do_reset(2'd3, 4'b1001, 2'b01, 1'b0);
        tog = 0; prev = inv_o;
        for (int i = 0; i < 2 * CFRAME; i++) begin
            step(1'b1, "R7 frame inversion");
            if (inv_o != prev) tog++;
            prev = inv_o;
        end
        check("R7 frame toggles", 32'(tog), 32'd2);
        do_reset(2'd3, 4'b1001, 2'b01, 1'b1);
        tog = 0; prev = inv_o;
        for (int i = 0; i < CFRAME; i++) begin
            step(1'b1, "R7 line inversion");
            if (inv_o != prev) tog++;
            prev = inv_o;
        end
        check("R7 line toggles", 32'(tog), 32'(CVA + CVF + CVS + CVB));
    endtask

    task automatic test_latch();
        do_reset(2'd3, 4'b1001, 2'b01, 1'b1);
        run(20, "R8 before change");
        pol_cfg = 4'b0110; sync_sel = 2'b10; line_inv = 1'b0;
        run(CFRAME - 20, "R8 old settings held");
        check("R8 new polarity live", {31'd0, dclk_rise_o}, 32'd0);
        run(CFRAME, "R8 new settings");
    endtask

    task automatic test_modes();
        do_reset(2'd1, 4'b1001, 2'b01, 1'b1);
        run(3 * 921 + 4, "R1 mode 1");
        check("R1 mode 1 line count", {20'd0, v_pos}, 32'd3);
        do_reset(2'd2, 4'b1001, 2'b01, 1'b1);
        run(3 * 916 + 4, "R1 mode 2");
        check("R1 mode 2 line count", {20'd0, v_pos}, 32'd3);
        do_reset(2'd3, 4'b1001, 2'b01, 1'b1);
        run(30, "R8 pre switch");
        mode_sel = 2'd0;
        run(CFRAME - 30, "R8 custom until wrap");
        run(409 * 262, "R1 mode 0 frame");
        check("R1 mode 0 wrap", {8'd0, h_pos, v_pos}, 32'd0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_frame();
        test_enable();
        test_smodes();
        test_polarity();
        test_inversion();
        test_latch();
        test_modes();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule